// File: doc/BRIEF.md
# MII Receive Nibble-to-Word Packer

This block sits directly on the receive side of a 100 Mbit/s media-independent interface and runs in the receive clock domain. It takes one 4-bit nibble per clock, together with the data-valid and receive-error strobes. It discards the preamble, locks on the start-of-frame delimiter and gathers the frame body into 32-bit words. Each word leaves on a single-cycle valid strobe. The strobe carries a start-of-frame mark, an end-of-frame mark, a count of the nibbles it holds, and two error flags.

The receiver will not accept a delimiter unless it has first sampled data-valid low. This applies after reset, after every frame and after every abandoned attempt, so it never locks onto the tail of a frame it joined late. When data-valid falls, the nibbles gathered so far leave as the closing word. That word reports two things: whether a receive error or an odd nibble count was seen, and whether the running CRC-32 over the frame body ends on the expected residue. The receiver can accept a new delimiter on the cycle after data-valid falls, so the shortest legal inter-frame gap plus preamble is always enough.

Top module: `mii_rx_packer`

## Requirements
- R1: After reset, and after any frame ends or is abandoned, no delimiter is accepted until `rx_dv` has been sampled low on at least one clock. A frame already in progress when reset is released produces no output, even if it contains the delimiter pattern.
- R2: A frame starts only when nibble 0x5 is followed at once by nibble 0xD, both sampled with `rx_dv` high. Any other value before the delimiter abandons the attempt, and so does 0xD with no 0x5 before it. A delimiter followed at once by `rx_dv` low produces no output.
- R3: Body nibbles fill a word starting at the least significant end. The first nibble after the delimiter goes to bits [3:0], and each later nibble goes 4 bits higher. A full word leaves with `out_nibbles` = 8 on the clock after the next body nibble, or the low `rx_dv`, is sampled.
- R4: `out_sof` is 1 on the first word of a frame and 0 on every later word.
- R5: The last word of a frame has `out_eof` = 1 and leaves on the clock after `rx_dv` is sampled low. Its `out_nibbles` is 1 to 8, its unfilled upper nibbles are zero, and a frame whose length is a multiple of 8 nibbles marks its last full word.
- R6: `out_err` is 1 on the last word when `rx_er` was high on any body nibble, or when the body holds an odd number of nibbles. It is 0 on every other word.
- R7: A CRC-32 runs over all body nibbles, including the frame check sequence. It uses the reflected polynomial 0xEDB88320, starts from all ones, and takes each nibble bit 0 first. `out_crc_err` is 1 on the last word when the final register is not 0xDEBB20E3, and 0 otherwise.
- R8: A new delimiter is accepted from the clock after `rx_dv` is sampled low. Frames separated by a single low cycle, or preceded by a single 0x5, are both received in full.
- R9: When `out_valid` is 0, the flags `out_sof`, `out_eof`, `out_err` and `out_crc_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one nibble per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 4 | Receive nibble from the PHY |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error strobe |
| out_valid | output | 1 | One-cycle strobe for an output word |
| out_data | output | 32 | Packed word, first nibble in bits [3:0] |
| out_sof | output | 1 | First word of a frame |
| out_eof | output | 1 | Last word of a frame |
| out_nibbles | output | 4 | Number of valid nibbles in the word (1 to 8) |
| out_err | output | 1 | Receive error or odd length, on the last word |
| out_crc_err | output | 1 | CRC residue mismatch, on the last word |

## Verification
Frames are driven with body lengths that end exactly on a word boundary, on several different partial nibble counts, and on an odd count. Comparing the packed data and `out_nibbles` across these separates correct fill order from wrong boundary handling. Clean frames are set against frames with a flipped check-sequence bit, a single-cycle `rx_er`, and a trailing extra nibble, which keeps the three error causes apart on the two flags. Late join at reset, a broken preamble, a delimiter with no 0x5 before it, and an empty frame must all stay silent. A single-cycle gap followed by a one-nibble preamble shows that the receiver re-arms fast enough.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

  typedef enum logic [1:0] {
    RX_WAIT_LOW,
    RX_IDLE,
    RX_PRE,
    RX_DATA
  } rx_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;

  // Advance a reflected CRC-32 register by one nibble, bit 0 first.
  function automatic logic [31:0] crc32_nibble(input logic [31:0] cur, input logic [3:0] nib);
    logic [31:0] r;
    r = cur;
    for (int i = 0; i < 4; i++) begin
      if (r[0] ^ nib[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else               r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
  import mii_rx_pkg::*;
#(
  parameter int          NIB_W   = 4,
  parameter logic [3:0]  PRE_NIB = 4'h5,
  parameter logic [3:0]  SFD_NIB = 4'hD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_dv,
  input  logic [NIB_W-1:0] rxd,
  output logic             data_en,
  output logic             frame_start,
  output logic             frame_end
);

  rx_state_e state_q, state_d;
  logic      armed;

  assign armed       = (state_q != RX_WAIT_LOW);
  assign data_en     = (state_q == RX_DATA) && rx_dv;
  assign frame_start = (state_q == RX_PRE) && rx_dv && (rxd == PRE_NIB[NIB_W-1:0] ? 1'b0 : rxd == SFD_NIB[NIB_W-1:0]);
  assign frame_end   = (state_q == RX_DATA) && !rx_dv;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RX_WAIT_LOW: if (!rx_dv) state_d = RX_IDLE;
      RX_IDLE: begin
        if (rx_dv) state_d = (rxd == PRE_NIB[NIB_W-1:0]) ? RX_PRE : RX_WAIT_LOW;
      end
      RX_PRE: begin
        if (!rx_dv)                          state_d = RX_IDLE;
        else if (rxd == SFD_NIB[NIB_W-1:0])  state_d = RX_DATA;
        else if (rxd != PRE_NIB[NIB_W-1:0])  state_d = RX_WAIT_LOW;
      end
      RX_DATA: if (!rx_dv) state_d = RX_IDLE;
      default: state_d = RX_WAIT_LOW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RX_WAIT_LOW;
    else        state_q <= state_d;
  end

  // R1: leaving the locked-out state needs a sampled low data-valid
  assert_arm_after_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(!rx_dv));

  // R2: a start is always preceded by a preamble nibble under data-valid
  assert_start_after_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ($past(rx_dv) && $past(rxd) == PRE_NIB[NIB_W-1:0]));

  // R5: an end only follows a start or a body nibble
  assert_end_follows_body_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> ($past(data_en) || $past(frame_start)));

endmodule

// File: rtl/mii_rx_crc.sv
module mii_rx_crc
  import mii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       data_en,
  input  logic [3:0] rxd,
  output logic       crc_ok
);

  logic [31:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           crc_q <= CRC_SEED;
    else if (frame_start) crc_q <= CRC_SEED;
    else if (data_en)     crc_q <= crc32_nibble(crc_q, rxd);
  end

  assign crc_ok = (crc_q == CRC_RESIDUE);

endmodule

// File: rtl/mii_rx_word_acc.sv
module mii_rx_word_acc #(
  parameter int WORD_W = 32,
  parameter int NIB_W  = 4,
  localparam int NPW   = WORD_W / NIB_W,
  localparam int CNT_W = $clog2(NPW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              data_en,
  input  logic              frame_end,
  input  logic [NIB_W-1:0]  rxd,
  input  logic              rx_er,
  input  logic              crc_ok,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic [CNT_W-1:0]  out_nibbles,
  output logic              out_err,
  output logic              out_crc_err
);

  logic [WORD_W-1:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              first_q;
  logic              er_q;
  logic              word_full;
  logic              word_push;
  logic              tail_push;

  assign word_full = (cnt_q == CNT_W'(NPW));
  assign word_push = data_en && word_full;
  assign tail_push = frame_end && (cnt_q != '0);

  // Drop a nibble into slot idx of the word, lowest slot first.
  function automatic logic [WORD_W-1:0] put_nibble(input logic [WORD_W-1:0] w,
                                                   input logic [CNT_W-1:0]  idx,
                                                   input logic [NIB_W-1:0]  nib);
    logic [WORD_W-1:0] r;
    r = w;
    for (int i = 0; i < NPW; i++) begin
      if (idx == CNT_W'(i)) r[i*NIB_W +: NIB_W] = nib;
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      cnt_q       <= '0;
      first_q     <= 1'b0;
      er_q        <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_sof     <= 1'b0;
      out_eof     <= 1'b0;
      out_nibbles <= '0;
      out_err     <= 1'b0;
      out_crc_err <= 1'b0;
    end else begin
      out_valid   <= 1'b0;
      out_sof     <= 1'b0;
      out_eof     <= 1'b0;
      out_err     <= 1'b0;
      out_crc_err <= 1'b0;
      if (frame_start) begin
        acc_q   <= '0;
        cnt_q   <= '0;
        first_q <= 1'b1;
        er_q    <= 1'b0;
      end else if (data_en) begin
        er_q <= er_q | rx_er;
        if (word_push) begin
          out_valid   <= 1'b1;
          out_data    <= acc_q;
          out_nibbles <= cnt_q;
          out_sof     <= first_q;
          first_q     <= 1'b0;
          acc_q       <= put_nibble('0, '0, rxd);
          cnt_q       <= CNT_W'(1);
        end else begin
          acc_q <= put_nibble(acc_q, cnt_q, rxd);
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end else if (frame_end) begin
        if (tail_push) begin
          out_valid   <= 1'b1;
          out_data    <= acc_q;
          out_nibbles <= cnt_q;
          out_sof     <= first_q;
          out_eof     <= 1'b1;
          out_err     <= er_q | cnt_q[0];
          out_crc_err <= !crc_ok;
        end
        cnt_q <= '0;
      end
    end
  end

  // R3: a word that does not close the frame is always full
  assert_full_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eof) |-> (out_nibbles == CNT_W'(NPW)));

  // R5: nibble count of any emitted word lies in 1..NPW
  assert_nib_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_nibbles != '0 && out_nibbles <= CNT_W'(NPW)));

  // R5: nothing can follow a closing word on the very next cycle
  assert_eof_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |=> !out_valid);

  // R7: CRC verdict only on the closing word
  assert_crc_on_eof_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_crc_err |-> out_eof);

  // R9: flags stay quiet without a word
  assert_flags_need_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_sof || out_eof || out_err || out_crc_err));

endmodule

// File: rtl/mii_rx_packer.sv
module mii_rx_packer #(
  parameter int WORD_W = 32,
  parameter int NIB_W  = 4,
  localparam int NPW   = WORD_W / NIB_W,
  localparam int CNT_W = $clog2(NPW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  rxd,
  input  logic              rx_dv,
  input  logic              rx_er,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic [CNT_W-1:0]  out_nibbles,
  output logic              out_err,
  output logic              out_crc_err
);

  logic data_en;
  logic frame_start;
  logic frame_end;
  logic crc_ok;

  mii_rx_framer #(.NIB_W(NIB_W)) framer_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_dv       (rx_dv),
    .rxd         (rxd),
    .data_en     (data_en),
    .frame_start (frame_start),
    .frame_end   (frame_end)
  );

  mii_rx_crc crc_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .data_en     (data_en),
    .rxd         (rxd[3:0]),
    .crc_ok      (crc_ok)
  );

  mii_rx_word_acc #(.WORD_W(WORD_W), .NIB_W(NIB_W)) acc_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .data_en     (data_en),
    .frame_end   (frame_end),
    .rxd         (rxd),
    .rx_er       (rx_er),
    .crc_ok      (crc_ok),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_sof     (out_sof),
    .out_eof     (out_eof),
    .out_nibbles (out_nibbles),
    .out_err     (out_err),
    .out_crc_err (out_crc_err)
  );

  // R9: a frame opening word is a real word
  assert_sof_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

endmodule

// File: tb/mii_rx_packer_tb.sv
`timescale 1ns/1ps
module mii_rx_packer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rxd = 4'h7;
  logic        rx_dv = 1'b1;
  logic        rx_er = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_sof;
  logic        out_eof;
  logic [3:0]  out_nibbles;
  logic        out_err;
  logic        out_crc_err;

  always #2.5 clk = ~clk;

  mii_rx_packer dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .out_nibbles(out_nibbles), .out_err(out_err), .out_crc_err(out_crc_err)
  );

  // Stimulus table: body bytes, rx_er nibble index (-1 none), corrupt FCS,
  // extra trailing nibble, preamble length; then expected word count,
  // last word nibble count, error flag, CRC error flag.
  localparam int NV = 6;
  localparam int V_BYTES  [NV] = '{4, 5, 7, 6, 9, 1};
  localparam int V_ER_AT  [NV] = '{-1, -1, -1, -1, 5, -1};
  localparam int V_CORRUPT[NV] = '{0, 0, 1, 0, 0, 0};
  localparam int V_EXTRA  [NV] = '{0, 0, 0, 1, 0, 0};
  localparam int V_PRE    [NV] = '{15, 15, 15, 15, 15, 1};
  localparam int V_WORDS  [NV] = '{2, 3, 3, 3, 4, 2};
  localparam int V_LASTN  [NV] = '{8, 2, 6, 5, 2, 2};
  localparam int V_ERR    [NV] = '{0, 0, 0, 1, 1, 0};
  localparam int V_CRCERR [NV] = '{0, 0, 1, 1, 0, 0};

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int idle_flag_hits = 0;

  logic [3:0] fnib [0:127];
  logic       fer  [0:127];
  int         flen;

  logic [31:0] got_data [0:31];
  logic [3:0]  got_nib  [0:31];
  logic        got_sof  [0:31];
  logic        got_eof  [0:31];
  logic        got_err  [0:31];
  logic        got_crc  [0:31];
  int          got_n = 0;

  always @(negedge clk) begin
    if (rst_n && out_valid && got_n < 32) begin
      got_data[got_n] = out_data;
      got_nib[got_n]  = out_nibbles;
      got_sof[got_n]  = out_sof;
      got_eof[got_n]  = out_eof;
      got_err[got_n]  = out_err;
      got_crc[got_n]  = out_crc_err;
      got_n++;
    end
    if (rst_n && !out_valid && (out_sof || out_eof || out_err || out_crc_err))
      idle_flag_hits++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic dv, input logic [3:0] d, input logic er);
    @(negedge clk);
    rx_dv = dv;
    rxd   = d;
    rx_er = er;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 4'h0, 1'b0);
  endtask

  // CRC-32, reflected, processed a byte at a time
  function automatic logic [31:0] byte_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic build(input int v);
    logic [31:0] c;
    logic [31:0] fcs;
    logic [7:0]  b;
    c = 32'hFFFFFFFF;
    flen = 0;
    for (int i = 0; i < V_BYTES[v]; i++) begin
      b = 8'((i * 37 + v * 11 + 3) & 255);
      c = byte_crc(c, b);
      fnib[flen] = b[3:0]; flen++;
      fnib[flen] = b[7:4]; flen++;
    end
    fcs = ~c;
    if (V_CORRUPT[v] != 0) fcs[0] = ~fcs[0];
    for (int i = 0; i < 8; i++) begin
      fnib[flen] = fcs[i*4 +: 4]; flen++;
    end
    if (V_EXTRA[v] != 0) begin
      fnib[flen] = 4'hA; flen++;
    end
    for (int i = 0; i < flen; i++) fer[i] = (i == V_ER_AT[v]);
  endtask

  task automatic send(input int pre_len);
    for (int i = 0; i < pre_len; i++) tick(1'b1, 4'h5, 1'b0);
    tick(1'b1, 4'hD, 1'b0);
    for (int i = 0; i < flen; i++) tick(1'b1, fnib[i], fer[i]);
    tick(1'b0, 4'h0, 1'b0);
  endtask

  function automatic logic [31:0] exp_word(input int k);
    logic [31:0] d;
    d = '0;
    for (int i = 0; i < 8; i++)
      if (8 * k + i < flen) d[i*4 +: 4] = fnib[8 * k + i];
    return d;
  endfunction

  task automatic compare(input int v);
    bit last;
    check(got_n == V_WORDS[v], "R5 word count", got_n, V_WORDS[v]);
    for (int k = 0; k < got_n && k < V_WORDS[v]; k++) begin
      last = (k == V_WORDS[v] - 1);
      check(got_data[k] == exp_word(k), "R3 word data", got_data[k], exp_word(k));
      check(got_nib[k] == (last ? V_LASTN[v] : 8), "R5 nibble count", got_nib[k], last ? V_LASTN[v] : 8);
      check(got_sof[k] == (k == 0), "R4 start flag", got_sof[k], k == 0);
      check(got_eof[k] == last, "R5 end flag", got_eof[k], last);
      check(got_err[k] == (last && V_ERR[v] != 0), "R6 error flag", got_err[k], last && V_ERR[v] != 0);
      check(got_crc[k] == (last && V_CRCERR[v] != 0), "R7 crc flag", got_crc[k], last && V_CRCERR[v] != 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Reset held while a frame is already running on the wire.
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R9 reset valid", out_valid, 0);
    check(out_data == 32'h0, "R9 reset data", out_data, 0);
    rst_n = 1'b1;

    // R1: joined mid-frame, delimiter pattern seen before any low data-valid
    got_n = 0;
    tick(1'b1, 4'h5, 1'b0); tick(1'b1, 4'h5, 1'b0); tick(1'b1, 4'hD, 1'b0);
    for (int i = 0; i < 20; i++) tick(1'b1, 4'(i), 1'b0);
    gap(24);
    check(got_n == 0, "R1 late join silent", got_n, 0);

    // Table walk with minimum gaps
    for (int v = 0; v < NV; v++) begin
      build(v);
      got_n = 0;
      send(V_PRE[v]);
      gap(23);
      compare(v);
    end

    // R2: broken preamble abandons the attempt
    got_n = 0;
    tick(1'b1, 4'h5, 1'b0); tick(1'b1, 4'h5, 1'b0); tick(1'b1, 4'h3, 1'b0);
    tick(1'b1, 4'h5, 1'b0); tick(1'b1, 4'hD, 1'b0);
    for (int i = 0; i < 12; i++) tick(1'b1, 4'(i + 1), 1'b0);
    gap(10);
    check(got_n == 0, "R2 bad preamble silent", got_n, 0);

    // R2: delimiter with no preamble nibble before it
    got_n = 0;
    tick(1'b1, 4'hD, 1'b0);
    for (int i = 0; i < 12; i++) tick(1'b1, 4'(i + 2), 1'b0);
    gap(10);
    check(got_n == 0, "R2 bare delimiter silent", got_n, 0);

    // R2: empty frame
    got_n = 0;
    tick(1'b1, 4'h5, 1'b0); tick(1'b1, 4'hD, 1'b0);
    gap(10);
    check(got_n == 0, "R2 empty frame silent", got_n, 0);

    // R8: two frames separated by a single low cycle
    build(0);
    got_n = 0;
    send(15);
    send(1);
    gap(10);
    check(got_n == 4, "R8 back-to-back count", got_n, 4);
    check(got_n == 4 && got_sof[2] == 1'b1, "R8 second frame start", got_sof[2], 1);
    check(got_n == 4 && got_eof[3] == 1'b1 && got_crc[3] == 1'b0, "R8 second frame end", got_eof[3], 1);
    check(got_n == 4 && got_data[2] == exp_word(0), "R8 second frame data", got_data[2], exp_word(0));

    check(idle_flag_hits == 0, "R9 idle flags", idle_flag_hits, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule